// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers the interrupt events of a host bus bridge into one status register and turns them into a single level-sensitive request to the CPU. The events are DMA descriptor events (completion, success, error, end of list and out-of-descriptors, in bits 0 to 7 and 9), the external device interrupt line (bit 25) and the bus abort event (bit 26). A one-cycle pulse on an event input sets its status bit. The bit stays set until software writes a one to it.

Each status bit has a mask bit, and a single global enable gates the final CPU line. The block also gives the index of the lowest-numbered pending bit, where pending means set in both status and mask. Software can dispatch on that index at once instead of scanning the register. Software reaches all three registers through a simple write-strobe and address interface with combinational read data. All three reset to zero.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the status, mask and enable registers all read 0, `cpu_irq` is 0, `pend_valid` is 0 and `pend_idx` is 0.
- R2: A high level on `src_evt[i]` at a clock edge sets status bit i. The bit stays set after the source drops, for as long as it is not cleared.
- R3: A write to offset 0x500 clears every status bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R4: Suppose a source event and a clearing write hit the same status bit at the same clock edge. The event wins and the bit stays set.
- R5: The mask register at offset 0x504 reads back what was written, limited to bits 0..26. A status bit counts as pending only while its mask bit is 1.
- R6: The enable register at offset 0x508 stores write-data bit 0 only. It reads back as 0 or 1, with all higher bits read as 0.
- R7: `cpu_irq` is 1 exactly when enable is 1 and at least one status bit is pending. It stays high for as long as that holds, with no new events needed.
- R8: `pend_valid` is 1 when any bit is pending, whatever the global enable, and `pend_idx` then gives the lowest-numbered pending bit. With nothing pending, `pend_valid` is 0 and `pend_idx` is 0.
- R9: Writes to any offset other than 0x500, 0x504 and 0x508 change no register. Reads of such offsets return 0, and status bits 27..31 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | 27 | Event inputs; bit 25 is the external device line, bit 26 is bus abort |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| cpu_irq | output | 1 | Level interrupt request to the CPU |
| pend_valid | output | 1 | At least one status bit is pending (set and unmasked) |
| pend_idx | output | 5 | Index of the lowest-numbered pending bit |

## Verification
The bench drives an event into a bit in the same cycle as a clearing write to that bit. A design that let the clear win would drop an interrupt, and the status readback would show the bit as 0. It sets several bits that lie far apart (0, 9, 26) and clears them one at a time. An encoder that picked the highest bit, or failed to skip masked bits, would report the wrong index. It toggles the global enable while a bit is pending, to show that only `cpu_irq` follows the enable while `pend_valid` does not. It also writes all ones to unused offsets and to the upper register bits, which would expose decoding that aliases addresses or keeps bits that do not exist.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int unsigned MAX_SRC    = 32;
  localparam int unsigned OFS_STATUS = 32'h500;
  localparam int unsigned OFS_MASK   = 32'h504;
  localparam int unsigned OFS_ENABLE = 32'h508;
  localparam int unsigned BIT_EXT    = 25;
  localparam int unsigned BIT_ABORT  = 26;

  // Index of the least significant one; 0 when the vector is empty.
  function automatic int unsigned lowest_one(input logic [MAX_SRC-1:0] v);
    int unsigned r;
    r = 0;
    for (int i = MAX_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Next value of one sticky bit: a set beats a clear.
  function automatic logic sticky_next(input logic cur, input logic set,
                                       input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NUM_SRC = 27
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] status
);
  import irq_agg_pkg::*;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status[g] <= 1'b0;
      else        status[g] <= sticky_next(status[g], set_vec[g], clr_vec[g]);
    end
  end

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int NUM_SRC = 27
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_we,
  input  logic               en_we,
  input  logic [NUM_SRC-1:0] wr_bits,
  output logic [NUM_SRC-1:0] mask_q,
  output logic               en_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (mask_we) mask_q <= wr_bits;
      if (en_we)   en_q   <= wr_bits[0];
    end
  end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_SRC = 27,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_SRC-1:0] pend_vec,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  import irq_agg_pkg::*;

  logic [MAX_SRC-1:0] wide;

  assign wide = MAX_SRC'(pend_vec);
  assign any  = |pend_vec;
  assign idx  = IDX_W'(lowest_one(wide));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NUM_SRC = 27,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               cpu_irq,
  output logic               pend_valid,
  output logic [IDX_W-1:0]   pend_idx
);
  import irq_agg_pkg::*;

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);

  // Named internal events, visible to the bound checker.
  logic               hit_status, hit_mask, hit_enable;
  logic [NUM_SRC-1:0] wr_bits;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] mask_q;
  logic               en_q;
  logic [NUM_SRC-1:0] pend_vec;
  logic               unused_wdata_hi;

  assign hit_status = reg_addr == A_STATUS;
  assign hit_mask   = reg_addr == A_MASK;
  assign hit_enable = reg_addr == A_ENABLE;
  assign wr_bits    = reg_wdata[NUM_SRC-1:0];
  assign clr_vec    = (reg_wr && hit_status) ? wr_bits : '0;
  assign unused_wdata_hi = ^(reg_wdata >> NUM_SRC);

  irq_status_bank #(.NUM_SRC(NUM_SRC)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (src_evt),
    .clr_vec (clr_vec),
    .status  (status_q)
  );

  irq_ctrl_regs #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_we (reg_wr && hit_mask),
    .en_we   (reg_wr && hit_enable),
    .wr_bits (wr_bits),
    .mask_q  (mask_q),
    .en_q    (en_q)
  );

  assign pend_vec = status_q & mask_q;

  irq_prio_enc #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_enc (
    .pend_vec (pend_vec),
    .any      (pend_valid),
    .idx      (pend_idx)
  );

  assign cpu_irq = en_q & pend_valid;

  always_comb begin
    reg_rdata = '0;
    if (hit_status)      reg_rdata = DATA_W'(status_q);
    else if (hit_mask)   reg_rdata = DATA_W'(mask_q);
    else if (hit_enable) reg_rdata = DATA_W'(en_q);
  end

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int NUM_SRC = 27,
  parameter int IDX_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_evt,
  input logic [NUM_SRC-1:0] clr_vec,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               en_q,
  input logic               cpu_irq,
  input logic               pend_valid,
  input logic [IDX_W-1:0]   pend_idx
);

  logic [NUM_SRC-1:0] chk_pend;
  assign chk_pend = status_q & mask_q;

  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((status_q & $past(src_evt)) == $past(src_evt))); // R2 R4

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~src_evt)) |=> ((status_q & $past(clr_vec & ~src_evt)) == '0)); // R3

  AST_HOLD_NO_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt == '0 && clr_vec == '0) |=> $stable(status_q)); // R2

  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q || chk_pend == '0) |-> !cpu_irq); // R7

  AST_IRQ_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && chk_pend != '0) |-> cpu_irq); // R7

  AST_IDX_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> chk_pend[pend_idx]); // R8

  AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> ((chk_pend & ~({NUM_SRC{1'b1}} << pend_idx)) == '0)); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid |-> (pend_idx == '0 && chk_pend == '0)); // R8

endmodule

bind irq_aggregator irq_aggregator_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_evt    (src_evt),
  .clr_vec    (clr_vec),
  .status_q   (status_q),
  .mask_q     (mask_q),
  .en_q       (en_q),
  .cpu_irq    (cpu_irq),
  .pend_valid (pend_valid),
  .pend_idx   (pend_idx)
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;

  localparam int NS = 27;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_evt = '0;
  logic          reg_wr = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          cpu_irq, pend_valid;
  logic [4:0]    pend_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_irq(cpu_irq), .pend_valid(pend_valid), .pend_idx(pend_idx)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Advance one edge, then settle away from it.
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [NS-1:0] v);
    src_evt = v;
    tick();
    src_evt = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h500, d); check("R1", "status", d, 0);
    rd(12'h504, d); check("R1", "mask", d, 0);
    rd(12'h508, d); check("R1", "enable", d, 0);
    check("R1", "irq/valid/idx", {cpu_irq, pend_valid, pend_idx}, 0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse(27'h200_0008);
    repeat (3) tick();
    rd(12'h500, d); check("R2", "status after pulses", d, 32'h0200_0008);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(12'h500, 32'h0000_0008);
    rd(12'h500, d); check("R3", "clear bit3 only", d, 32'h0200_0000);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    src_evt = 27'h200_0000;
    wr(12'h500, 32'h0200_0000);
    src_evt = '0;
    rd(12'h500, d); check("R4", "set beats clear", d, 32'h0200_0000);
    wr(12'h500, 32'hFFFF_FFFF);
    rd(12'h500, d); check("R3", "clear all", d, 0);
  endtask

  task automatic t_mask_enable();
    logic [31:0] d;
    pulse(27'h000_0020);
    wr(12'h508, 32'hFFFF_FFFF);
    rd(12'h508, d); check("R6", "enable readback", d, 1);
    check("R5", "masked bit not pending", {cpu_irq, pend_valid}, 0);
    wr(12'h504, 32'hFFFF_FFFF);
    rd(12'h504, d); check("R5", "mask readback width", d, 32'h07FF_FFFF);
    check("R7", "irq with pending", cpu_irq, 1);
    check("R8", "idx 5", {pend_valid, pend_idx}, {1'b1, 5'd5});
    repeat (4) tick();
    check("R7", "level held", cpu_irq, 1);
    wr(12'h508, 32'hFFFF_FFFE);
    rd(12'h508, d); check("R6", "enable only bit0", d, 0);
    check("R7", "irq off when disabled", cpu_irq, 0);
    check("R8", "valid ignores enable", pend_valid, 1);
    wr(12'h508, 32'h1);
    wr(12'h500, 32'h20);
    check("R7", "irq drops after clear", cpu_irq, 0);
  endtask

  task automatic t_priority();
    pulse(27'h400_0201);
    check("R8", "lowest is 0", {pend_valid, pend_idx}, {1'b1, 5'd0});
    wr(12'h500, 32'h1);
    check("R8", "lowest is 9", pend_idx, 9);
    wr(12'h504, 32'h0400_0000);
    check("R5", "mask hides 9", pend_idx, 26);
    wr(12'h504, 32'h07FF_FFFF);
    wr(12'h500, 32'h200);
    check("R8", "abort bit 26", pend_idx, 26);
    check("R7", "irq for abort", cpu_irq, 1);
    wr(12'h500, 32'h0400_0000);
    check("R8", "none pending", {cpu_irq, pend_valid, pend_idx}, 0);
  endtask

  task automatic t_other();
    logic [31:0] d;
    pulse(27'h000_0100);
    wr(12'h50C, 32'hFFFF_FFFF);
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h000, 32'h0);
    rd(12'h500, d); check("R9", "status untouched", d, 32'h0000_0100);
    rd(12'h504, d); check("R9", "mask untouched", d, 32'h07FF_FFFF);
    rd(12'h508, d); check("R9", "enable untouched", d, 1);
    rd(12'h50C, d); check("R9", "unmapped reads 0", d, 0);
    check("R8", "idx 8", pend_idx, 8);
  endtask

  initial begin
    #35;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_sticky();
    t_w1c();
    t_collide();
    t_mask_enable();
    t_priority();
    t_other();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule